// File: doc/BRIEF.md
# Dual-Slot Transmit Buffer Controller

This block holds two outgoing Ethernet frames for a simple MAC and feeds them, one byte at a time, to a downstream transmitter. Software picks a slot through a slot-select register, pushes the frame as 32-bit words into one shared data port, writes that slot's byte length and then sets the slot's start bit. Each slot is armed, sent and reported on its own. A small order queue makes sure the slots go out in the order they were started.

While a slot is armed, its storage and length are frozen. Writes that target it are dropped. When the final byte of a frame is accepted downstream, the slot's start bit falls and its completion flag rises. The completion flags are write-one-to-clear and are masked by an enable register into one interrupt line. CRC, padding, DMA and line signalling belong to other blocks.

Register map (byte offsets, word-aligned; an access outside the map reads 0 and writes nothing):

| Offset | Name | Access | Contents |
|---|---|---|---|
| 0x00 | slot-select | R/W | bit 0: slot filled by data-port writes |
| 0x04 | data port | W: push word; R: fill count | fill count of the selected slot, in words |
| 0x08 / 0x0C | length, slot 0 / slot 1 | R/W | frame length in bytes |
| 0x10 / 0x14 | control, slot 0 / slot 1 | R/W | bit 0: start (reads 1 while armed) |
| 0x18 | interrupt enable | R/W | bits[1:0] |
| 0x1C | completion status | R, write-1-to-clear | bits[1:0] |

Top module: `tx2_slot_ctrl`

## Requirements
- R1: After reset, every register reads 0, tx_valid is 0 and irq is 0.
- R2: A write to offset 0x00 selects slot bus_wdata[0] for data-port writes. It also clears that slot's fill count to 0, unless that slot is armed. A read of offset 0x04 returns the fill count, in words, of the selected slot.
- R3: Each write to offset 0x04 stores the word at the next free word of the selected slot and raises its fill count by one. The write is dropped when the slot is armed or already holds SLOT_BYTES/4 words.
- R4: A write to offset 0x08 (slot 0) or 0x0C (slot 1) sets that slot's length to min(bus_wdata, SLOT_BYTES). The write is dropped while the slot is armed.
- R5: Writing 1 to bit 0 at offset 0x10 (slot 0) or 0x14 (slot 1) arms that slot, but only if its length is non-zero. Otherwise the write is ignored and nothing is sent. The control register reads 1 while the slot is armed and 0 from the cycle after its last byte is accepted.
- R6: A frame is sent as exactly length bytes, least significant byte of each word first, with tx_last high on the final byte. tx_data and tx_last hold while tx_valid is high and tx_ready is low.
- R7: With both slots armed, frames go out in the order the slots were started. From idle, tx_valid rises one cycle after the start write takes effect.
- R8: Acceptance of the last byte of slot i sets completion bit i (bit 0 = slot 0, bit 1 = slot 1) at offset 0x1C. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: irq is high exactly when some completion bit and its matching enable bit at offset 0x18 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_valid | output | 1 | A frame byte is offered |
| tx_ready | input | 1 | Downstream accepts the offered byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Offered byte is the final one of the frame |
| irq | output | 1 | Masked completion interrupt |

## Verification
Every register write takes effect at the clock edge that samples it. Read data is combinational from the registers, so the bench drives the address half a cycle ahead of the next edge and samples just after.

A start write pushes the slot into the order queue at its edge. The transmitter loads the slot at the following edge, so tx_valid appears two edges after the write was driven. The start bit falls and the completion flag rises at the same edge that accepts the last byte. A second armed frame loads one edge after that.

A behavioural model built from queues and integers advances on each rising edge from the same inputs. On every falling edge it is compared with tx_valid, tx_data, tx_last and irq, so each of these due-cycle rules is checked in the exact cycle it applies.

// File: rtl/tx2_pkg.sv
package tx2_pkg;

   localparam int NUM_SLOTS = 2;

   // Register index = byte offset / 4; the length and control pairs sit one word apart
   typedef enum logic [2:0] {
      RG_SEL  = 3'd0,
      RG_DATA = 3'd1,
      RG_LEN0 = 3'd2,
      RG_LEN1 = 3'd3,
      RG_CTL0 = 3'd4,
      RG_CTL1 = 3'd5,
      RG_IEN  = 3'd6,
      RG_STAT = 3'd7
   } tx2_reg_e;

endpackage

// File: rtl/tx2_slot_mem.sv
module tx2_slot_mem #(
   parameter int AW = 11,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int ENTRIES = 1 << AW;

   logic [DW-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/tx2_order_q.sv
module tx2_order_q #(
   parameter int DEPTH = 2,
   parameter int ID_W  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [ID_W-1:0] push_id,
   input  logic            pop,
   output logic [ID_W-1:0] head,
   output logic            empty
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [ID_W-1:0] ent [DEPTH];
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   wr_idx;
   logic            do_push;
   logic            do_pop;

   assign empty   = (cnt_q == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (do_pop || (cnt_q != CW'(DEPTH)));
   assign wr_idx  = do_pop ? (cnt_q - CW'(1)) : cnt_q;
   assign head    = ent[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (do_push && (CW'(i) == wr_idx))
               ent[i] <= push_id;
            else if (do_pop && (i < DEPTH - 1))
               ent[i] <= ent[(i + 1) % DEPTH];
         end
         if (do_push && !do_pop)
            cnt_q <= cnt_q + CW'(1);
         else if (do_pop && !do_push)
            cnt_q <= cnt_q - CW'(1);
      end
   end

endmodule

// File: rtl/tx2_byte_ser.sv
module tx2_byte_ser #(
   parameter int LEN_W = 13,
   parameter int W_IDX = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_empty,
   input  logic             q_head,
   input  logic [LEN_W-1:0] head_len,
   output logic             pop,
   output logic [W_IDX:0]   rd_addr,
   input  logic [31:0]      rd_word,
   input  logic             tx_ready,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   output logic             done,
   output logic             cur_slot
);

   logic             active_q;
   logic             slot_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] cnt_inc;

   assign cnt_inc  = cnt_q + LEN_W'(1);
   assign pop      = !active_q && !q_empty;
   assign tx_valid = active_q;
   assign tx_last  = active_q && (cnt_inc == len_q);
   assign done     = active_q && tx_ready && tx_last;
   assign cur_slot = slot_q;
   assign rd_addr  = {slot_q, cnt_q[W_IDX+1:2]};
   assign tx_data  = rd_word[{cnt_q[1:0], 3'b000} +: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         slot_q   <= 1'b0;
         cnt_q    <= '0;
         len_q    <= '0;
      end else if (pop) begin
         active_q <= 1'b1;
         slot_q   <= q_head;
         cnt_q    <= '0;
         len_q    <= head_len;
      end else if (active_q && tx_ready) begin
         if (tx_last) active_q <= 1'b0;
         else         cnt_q    <= cnt_inc;
      end
   end

endmodule

// File: rtl/tx2_slot_ctrl.sv
module tx2_slot_ctrl
   import tx2_pkg::*;
#(
   parameter int SLOT_BYTES = 4096,
   parameter int ADDR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic              irq
);

   localparam int WORDS  = SLOT_BYTES / 4;
   localparam int W_IDX  = $clog2(WORDS);
   localparam int FILL_W = $clog2(WORDS + 1);
   localparam int LEN_W  = $clog2(SLOT_BYTES + 1);
   localparam int MEM_AW = W_IDX + 1;

   generate
      if (SLOT_BYTES < 8 || (SLOT_BYTES & (SLOT_BYTES - 1)) != 0) begin : g_bad_size
         $error("SLOT_BYTES must be a power of two, at least 8");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must cover the eight-word register map");
      end
      if (NUM_SLOTS != 2) begin : g_bad_slots
         $error("the register map is laid out for two slots");
      end
   endgenerate

   // Register state
   logic                 sel_q;
   logic [1:0]           ien_q;
   logic [1:0]           stat_q;
   logic [NUM_SLOTS-1:0] start_q;
   logic [LEN_W-1:0]     len_q  [NUM_SLOTS];
   logic [FILL_W-1:0]    fill_q [NUM_SLOTS];

   // Decode
   tx2_reg_e             reg_sel;
   logic                 addr_ok;
   logic                 wr;
   logic                 wr_sel, wr_data, wr_ien, wr_stat;
   logic [NUM_SLOTS-1:0] len_hit, ctl_hit, push_vec, done_vec;
   logic [LEN_W-1:0]     len_clamped;

   // Datapath links
   logic                 mem_we;
   logic [MEM_AW-1:0]    mem_waddr, mem_raddr;
   logic [31:0]          mem_rword;
   logic                 q_push, q_pop, q_empty, q_head;
   logic                 ser_done, cur_slot;

   assign reg_sel = tx2_reg_e'(bus_addr[4:2]);
   assign addr_ok = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
   assign wr      = bus_wr && addr_ok;
   assign wr_sel  = wr && (reg_sel == RG_SEL);
   assign wr_data = wr && (reg_sel == RG_DATA);
   assign wr_ien  = wr && (reg_sel == RG_IEN);
   assign wr_stat = wr && (reg_sel == RG_STAT);
   assign len_hit = {wr && (reg_sel == RG_LEN1), wr && (reg_sel == RG_LEN0)};
   assign ctl_hit = {wr && (reg_sel == RG_CTL1), wr && (reg_sel == RG_CTL0)};

   assign len_clamped = (bus_wdata > 32'(SLOT_BYTES)) ? LEN_W'(SLOT_BYTES)
                                                      : bus_wdata[LEN_W-1:0];

   always_comb begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
         push_vec[i] = ctl_hit[i] && bus_wdata[0] && !start_q[i] && (len_q[i] != '0);
         done_vec[i] = ser_done && (cur_slot == 1'(i));
      end
   end

   assign q_push    = |push_vec;
   assign mem_we    = wr_data && !start_q[sel_q] && (fill_q[sel_q] != FILL_W'(WORDS));
   assign mem_waddr = {sel_q, fill_q[sel_q][W_IDX-1:0]};
   assign irq       = |(stat_q & ien_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         ien_q   <= '0;
         stat_q  <= '0;
         start_q <= '0;
         for (int i = 0; i < NUM_SLOTS; i++) begin
            len_q[i]  <= '0;
            fill_q[i] <= '0;
         end
      end else begin
         if (wr_sel) sel_q <= bus_wdata[0];
         if (wr_ien) ien_q <= bus_wdata[1:0];
         stat_q <= (stat_q & ~({2{wr_stat}} & bus_wdata[1:0])) | done_vec;
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (len_hit[i] && !start_q[i])
               len_q[i] <= len_clamped;
            if (wr_sel && (bus_wdata[0] == 1'(i)) && !start_q[i])
               fill_q[i] <= '0;
            else if (mem_we && (sel_q == 1'(i)))
               fill_q[i] <= fill_q[i] + FILL_W'(1);
            if (done_vec[i])
               start_q[i] <= 1'b0;
            else if (push_vec[i])
               start_q[i] <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (addr_ok) begin
         case (reg_sel)
            RG_SEL:  bus_rdata[0]          = sel_q;
            RG_DATA: bus_rdata[FILL_W-1:0] = fill_q[sel_q];
            RG_LEN0: bus_rdata[LEN_W-1:0]  = len_q[0];
            RG_LEN1: bus_rdata[LEN_W-1:0]  = len_q[1];
            RG_CTL0: bus_rdata[0]          = start_q[0];
            RG_CTL1: bus_rdata[0]          = start_q[1];
            RG_IEN:  bus_rdata[1:0]        = ien_q;
            RG_STAT: bus_rdata[1:0]        = stat_q;
            default: bus_rdata             = '0;
         endcase
      end
   end

   tx2_slot_mem #(.AW(MEM_AW), .DW(32)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (bus_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rword)
   );

   tx2_order_q #(.DEPTH(NUM_SLOTS), .ID_W(1)) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (q_push),
      .push_id (push_vec[1]),
      .pop     (q_pop),
      .head    (q_head),
      .empty   (q_empty)
   );

   tx2_byte_ser #(.LEN_W(LEN_W), .W_IDX(W_IDX)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_empty  (q_empty),
      .q_head   (q_head),
      .head_len (len_q[q_head]),
      .pop      (q_pop),
      .rd_addr  (mem_raddr),
      .rd_word  (mem_rword),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_last  (tx_last),
      .done     (ser_done),
      .cur_slot (cur_slot)
   );

endmodule

// File: rtl/tx2_slot_ctrl_chk.sv
module tx2_slot_ctrl_chk #(
   parameter int LEN_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             tx_last,
   input logic [7:0]       tx_data,
   input logic             irq,
   input logic [1:0]       start_q,
   input logic [1:0]       stat_q,
   input logic             ser_slot,
   input logic [LEN_W-1:0] len0,
   input logic [LEN_W-1:0] len1
);

   // R6: a stalled byte stays put
   a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R8 / R5: last-byte acceptance flags completion and disarms the slot
   a_r8_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=>
         (stat_q[$past(ser_slot)] && !start_q[$past(ser_slot)]));

   // R5: bytes only leave for an armed slot
   a_r5_send_armed: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> start_q[ser_slot]);

   // R4: length frozen while armed
   a_r4_len0_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q[0] && $past(start_q[0])) |-> (len0 == $past(len0)));

   a_r4_len1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q[1] && $past(start_q[1])) |-> (len1 == $past(len1)));

   // R9: an interrupt needs a pending completion
   a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_q != 2'b00));

endmodule

bind tx2_slot_ctrl tx2_slot_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .tx_last  (tx_last),
   .tx_data  (tx_data),
   .irq      (irq),
   .start_q  (start_q),
   .stat_q   (stat_q),
   .ser_slot (cur_slot),
   .len0     (len_q[0]),
   .len1     (len_q[1])
);

// File: tb/tx2_slot_ctrl_bench.sv
module tx2_slot_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SB         = 64;
   localparam int WORDS      = SB / 4;
   localparam int AW         = 8;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          tx_valid, tx_last, irq;
   logic [7:0]    tx_data;
   logic          tx_ready = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   tx2_slot_ctrl #(.SLOT_BYTES(SB), .ADDR_W(AW)) u_tx2_slot_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .irq(irq)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int rdy_mode = 0;

   // Behavioural reference model
   logic [31:0] m_mem [2][WORDS];
   int          m_fill [2];
   int          m_len  [2];
   bit          m_start [2];
   int          m_sel;
   bit [1:0]    m_en, m_stat;
   int          m_q [$];
   bit          m_active;
   int          m_cur, m_cnt, m_done, m_idx;

   task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, got, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < 2; s++) begin
            m_fill[s] = 0; m_len[s] = 0; m_start[s] = 0;
            for (int k = 0; k < WORDS; k++) m_mem[s][k] = '0;
         end
         m_sel = 0; m_en = 0; m_stat = 0; m_q.delete();
         m_active = 0; m_cur = 0; m_cnt = 0;
      end else begin
         m_done = -1;
         if (m_active) begin
            if (tx_ready) begin
               if (m_cnt == m_len[m_cur] - 1) begin
                  m_done = m_cur; m_active = 0;
               end else m_cnt++;
            end
         end else if (m_q.size() > 0) begin
            m_cur = m_q.pop_front(); m_active = 1; m_cnt = 0;
         end
         if (bus_wr) begin
            m_idx = int'(bus_addr[2]);
            case (bus_addr)
               8'h00: begin
                  m_sel = int'(bus_wdata[0]);
                  if (!m_start[m_sel]) m_fill[m_sel] = 0;
               end
               8'h04: if (!m_start[m_sel] && m_fill[m_sel] < WORDS) begin
                  m_mem[m_sel][m_fill[m_sel]] = bus_wdata;
                  m_fill[m_sel]++;
               end
               8'h08, 8'h0C: if (!m_start[m_idx])
                  m_len[m_idx] = (bus_wdata > 32'(SB)) ? SB : int'(bus_wdata);
               8'h10, 8'h14: if (bus_wdata[0] && !m_start[m_idx] && m_len[m_idx] != 0) begin
                  m_start[m_idx] = 1; m_q.push_back(m_idx);
               end
               8'h18: m_en = bus_wdata[1:0];
               8'h1C: m_stat = m_stat & ~bus_wdata[1:0];
               default: ;
            endcase
         end
         if (m_done >= 0) begin
            m_start[m_done] = 0; m_stat[m_done] = 1'b1;
         end
      end
   end

   // Per-cycle comparison, then drive tx_ready
   always @(negedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
         summary();
         $finish;
      end
      if (rst_n) begin
         check("R6/R7", 32'(tx_valid), 32'(m_active), "tx_valid vs model");
         if (m_active) begin
            check("R6", 32'(tx_data),
                  32'((m_mem[m_cur][m_cnt/4] >> (8*(m_cnt%4))) & 32'hFF), "tx_data byte");
            check("R6", 32'(tx_last), 32'(m_cnt == m_len[m_cur] - 1), "tx_last");
         end
         check("R9", 32'(irq), 32'(|(m_stat & m_en)), "irq vs model");
      end
      case (rdy_mode)
         0: tx_ready = 1'b1;
         1: tx_ready = (cyc % 3) != 0;
         default: tx_ready = 1'b0;
      endcase
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, string req, string what);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      #1;
      check(req, bus_rdata, exp, what);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (m_active || m_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] pat(int s, int k);
      return 32'h1100_0000 * (s + 1) + 32'h0102_0304 * k + 32'h0050_A00B;
   endfunction

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int r = 0; r < 8; r++) rd_chk(8'(4*r), 32'h0, "R1", "register after reset");
      check("R1", 32'(tx_valid), 32'h0, "tx_valid after reset");
      check("R1", 32'(irq), 32'h0, "irq after reset");

      // Single frame from slot 0
      wr(8'h00, 0);
      wr(8'h04, 32'h4433_2211);
      wr(8'h04, 32'h8877_6655);
      wr(8'h04, 32'hCCBB_AA99);
      rd_chk(8'h04, 3, "R3", "fill count after three words");
      rd_chk(8'h00, 0, "R2", "slot select");
      wr(8'h08, 10);
      rd_chk(8'h08, 10, "R4", "length slot 0");
      wr(8'h18, 3);
      wr(8'h10, 1);
      rd_chk(8'h10, 1, "R5", "start reads armed");
      wait_idle();
      rd_chk(8'h10, 0, "R5", "start self-cleared");
      rd_chk(8'h1C, 1, "R8", "completion slot 0");
      check("R9", 32'(irq), 32'h1, "irq with flag and enable");
      wr(8'h1C, 1);
      rd_chk(8'h1C, 0, "R8", "flag cleared by write-one");

      // Two armed slots, started 1 then 0, downstream stalled
      rdy_mode = 2;
      wr(8'h00, 1);
      wr(8'h04, pat(1, 0));
      wr(8'h04, pat(1, 1));
      wr(8'h0C, 7);
      wr(8'h00, 0);
      wr(8'h04, pat(0, 0));
      wr(8'h04, pat(0, 1));
      wr(8'h08, 5);
      wr(8'h14, 1);
      wr(8'h10, 1);
      rd_chk(8'h10, 1, "R7", "slot 0 armed");
      rd_chk(8'h14, 1, "R7", "slot 1 armed");
      // Writes aimed at an armed slot
      wr(8'h00, 0);
      rd_chk(8'h04, 2, "R2", "armed slot keeps fill count on select");
      wr(8'h04, 32'hDEAD_BEEF);
      rd_chk(8'h04, 2, "R3", "data write to armed slot dropped");
      wr(8'h08, 33);
      rd_chk(8'h08, 5, "R4", "length write to armed slot dropped");
      rdy_mode = 1;
      wait_idle();
      rd_chk(8'h1C, 3, "R8", "both completion flags");
      wr(8'h18, 2);
      check("R9", 32'(irq), 32'h1, "irq via slot 1 enable");
      wr(8'h1C, 2);
      rd_chk(8'h1C, 1, "R8", "only bit 1 cleared");
      check("R9", 32'(irq), 32'h0, "irq masked for slot 0");
      wr(8'h1C, 1);

      // Capacity limits
      rdy_mode = 0;
      wr(8'h00, 1);
      for (int k = 0; k < WORDS + 1; k++) wr(8'h04, pat(1, k + 3));
      rd_chk(8'h04, WORDS, "R3", "fill count saturates at capacity");
      wr(8'h0C, 100);
      rd_chk(8'h0C, SB, "R4", "length clamped to capacity");
      wr(8'h14, 1);
      wait_idle();
      rd_chk(8'h14, 0, "R5", "full frame start cleared");
      rd_chk(8'h1C, 2, "R8", "completion slot 1");
      wr(8'h1C, 3);

      // Zero length start is ignored
      wr(8'h08, 0);
      rd_chk(8'h08, 0, "R4", "length zero stored");
      wr(8'h10, 1);
      rd_chk(8'h10, 0, "R5", "zero-length start ignored");
      repeat (3) @(negedge clk);
      #1;
      check("R5", 32'(tx_valid), 32'h0, "nothing sent for zero length");

      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule